// File: doc/BRIEF.md
# Latched-Address Eight-Way Bit Selector with Gated Outputs

The block picks one bit out of eight stored data bits and presents it on two outputs: the bit itself and its inverse. The bit is chosen by a 3-bit channel address, and both the address and the data sit in their own storage stages with their own controls. The address stage is always a transparent hold stage. The data stage is chosen at build time. It is either a transparent hold stage, or a stage that captures on the rising edge of a data strobe.

Both storage stages are built from system-clock flops. A transparent stage passes its live input straight through while its control is low. While the control is high it shows the value it sampled at the last clock edge at which the control was low. The edge-capture variant finds a rising edge of the data strobe at a system clock edge and captures the live data on that same edge.

Each output comes as a data bit, an active-high drive flag, and a bus pin that floats when the flag is low. All of them are gated by one three-input enable: two active-low terms and one active-high term.

Top module: `chan_pick_mux`

## Requirements
- R1: Channel address value k (0..7) selects stored data bit k, so address 0 gives `data_in[0]` and address 7 gives `data_in[7]`. The selected bit appears on `q_true`.
- R2: `q_comp` is always the inverse of `q_true`. When both outputs are driven, the two bus pins carry opposite levels.
- R3: `q_true_oe` and `q_comp_oe` are both 1 exactly when `oe_n_a`=0, `oe_n_b`=0 and `oe_c`=1, and both are 0 for the other seven combinations. While driven, each bus pin equals its data output. While not driven, the bus pin floats.
- R4: While `addr_hold` is low, the address stage is transparent. A change on `addr_in` reaches the outputs in the same cycle, with no clock edge needed.
- R5: While `addr_hold` is high, the address in use is the `addr_in` value sampled at the last clock edge at which `addr_hold` was low. Later changes on `addr_in` have no effect on the outputs.
- R6: In the transparent data variant (`DATA_KIND`=STAGE_LATCH), while `data_ctl` is low the outputs follow the live `data_in` in the same cycle.
- R7: In the transparent data variant, while `data_ctl` is high the data in use is the `data_in` value sampled at the last clock edge at which `data_ctl` was low. Later changes on `data_in` have no effect.
- R8: In the edge-capture variant (`DATA_KIND`=STAGE_FLOP), the stored data changes only at the first clock edge that samples `data_ctl` high after an edge that sampled it low. At that edge it takes the live `data_in`, and the new value shows after that edge. A held-high strobe, a falling strobe, a low strobe and data changes between strobes all leave the stored data unchanged.
- R9: A clock edge with `rst_n` low clears the stored address and the stored data to zero. After reset, with both controls high, `q_true`=0 (bit 0 of zero data).
- R10: Changing `oe_n_a`, `oe_n_b` or `oe_c` over any number of clock edges never alters the stored address or data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| data_in | input | N_CH (8) | Eight data sources |
| addr_in | input | SEL_W (3) | Channel address |
| addr_hold | input | 1 | Address stage control: low passes, high holds |
| data_ctl | input | 1 | Data stage control: hold when high (transparent variant), capture strobe on rising edge (edge variant) |
| oe_n_a | input | 1 | Active-low enable term |
| oe_n_b | input | 1 | Active-low enable term |
| oe_c | input | 1 | Active-high enable term |
| q_true | output | 1 | Selected stored bit |
| q_true_oe | output | 1 | Drive flag for the true output |
| q_comp | output | 1 | Inverse of the selected bit |
| q_comp_oe | output | 1 | Drive flag for the inverted output |
| q_true_bus | output | 1 | True output, floating when not driven |
| q_comp_bus | output | 1 | Inverted output, floating when not driven |

## Verification
The enable gating and the transparent paths of both stages (R3, R4, R6) are combinational. Their results are due in the cycle the stimulus is applied, so the bench drives at the falling clock edge and samples 1 ns later, before the next rising edge. A value that is held (R5, R7) is the one sampled at the rising edge before the control rises, so every load keeps the value steady across one rising edge with the control low before closing. Edge capture (R8) shows only after the rising clock edge that first sees the strobe high. The bench checks at 1 ns after raising the strobe that nothing has changed yet, and checks again after the following falling edge that the new value is present. Reset results (R9) are checked at the falling edge after the release.

// File: rtl/cpm_pkg.sv
`timescale 1ns/1ps
// cpm_pkg: shared types and helpers for the channel-pick multiplexer.
// Assumes nothing beyond the standard language.
package cpm_pkg;

    // Which storage style the data stage uses.
    typedef enum logic {
        STAGE_LATCH = 1'b0,
        STAGE_FLOP  = 1'b1
    } stage_kind_e;

    // Output enable: two active-low terms and one active-high term.
    function automatic logic drive_ok(input logic lo_a, input logic lo_b, input logic hi_c);
        return (!lo_a) && (!lo_b) && hi_c;
    endfunction

endpackage

// File: rtl/cpm_hold_stage.sv
`timescale 1ns/1ps
// cpm_hold_stage: transparent storage built from system-clock flops.
// While hold is low the visible value is the live input, and the
// register samples it on every clock edge. While hold is high the
// visible value is the register, i.e. the input sampled at the last
// edge with hold low. Assumes the input is steady across that edge.
module cpm_hold_stage #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         hold,
    input  logic [W-1:0] d,
    output logic [W-1:0] held,
    output logic [W-1:0] vis
);

    // Sample the input every edge the stage is open; clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held <= '0;
        end else if (!hold) begin
            held <= d;
        end
    end

    // Open stage bypasses the register so the input shows at once.
    assign vis = hold ? held : d;

endmodule

// File: rtl/cpm_edge_stage.sv
`timescale 1ns/1ps
// cpm_edge_stage: edge-capture storage. The strobe is sampled on the
// system clock. An edge that sees it high after an edge that saw it
// low captures the live data. Assumes the strobe stays high or low for
// at least one clock period.
module cpm_edge_stage #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         strobe,
    input  logic [W-1:0] d,
    output logic [W-1:0] held
);

    logic strobe_q;
    logic rise;

    // Track the strobe level, also through reset, so release makes no false edge.
    always_ff @(posedge clk) begin
        strobe_q <= strobe;
    end

    // Rising strobe as seen at this clock edge.
    assign rise = strobe && !strobe_q;

    // Capture on a rising strobe; clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held <= '0;
        end else if (rise) begin
            held <= d;
        end
    end

endmodule

// File: rtl/cpm_data_stage.sv
`timescale 1ns/1ps
// cpm_data_stage: data storage for the eight sources. KIND picks a
// transparent stage (control low = pass) or an edge-capture stage
// (rising control = capture). Only the chosen one is built.
module cpm_data_stage
    import cpm_pkg::*;
#(
    parameter int          N    = 8,
    parameter stage_kind_e KIND = STAGE_LATCH
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ctl,
    input  logic [N-1:0] d,
    output logic [N-1:0] held,
    output logic [N-1:0] vis
);

    generate
        if (KIND == STAGE_FLOP) begin : g_edge
            // Edge variant: the outputs always come from storage.
            cpm_edge_stage #(.W(N)) u_edge (
                .clk   (clk),
                .rst_n (rst_n),
                .strobe(ctl),
                .d     (d),
                .held  (held)
            );
            assign vis = held;
        end else begin : g_level
            // Transparent variant: pass while ctl low, hold while high.
            cpm_hold_stage #(.W(N)) u_level (
                .clk  (clk),
                .rst_n(rst_n),
                .hold (ctl),
                .d    (d),
                .held (held),
                .vis  (vis)
            );
        end
    endgenerate

endmodule

// File: rtl/cpm_out_stage.sv
`timescale 1ns/1ps
// cpm_out_stage: decodes the address to one data bit and drives the
// true and inverted outputs with a shared drive flag. Purely
// combinational. Assumes N <= 2**SW.
module cpm_out_stage
    import cpm_pkg::*;
#(
    parameter int N  = 8,
    parameter int SW = 3
) (
    input  logic [N-1:0]  data,
    input  logic [SW-1:0] addr,
    input  logic          lo_a,
    input  logic          lo_b,
    input  logic          hi_c,
    output logic          y,
    output logic          w,
    output logic          y_oe,
    output logic          w_oe
);

    logic pick;
    logic drive;

    // Full binary decode: pick the addressed bit.
    always_comb begin
        pick = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (addr == SW'(i)) pick = data[i];
        end
    end

    // One enable term drives both outputs.
    assign drive = drive_ok(lo_a, lo_b, hi_c);
    assign y     = pick;
    assign w     = ~pick;
    assign y_oe  = drive;
    assign w_oe  = drive;

endmodule

// File: rtl/chan_pick_mux.sv
`timescale 1ns/1ps
// chan_pick_mux: eight-way single-bit selector. The address is held in
// a transparent stage, the data in a stage chosen by DATA_KIND, and
// the result is driven as true and inverted outputs under a
// three-term enable. Synchronous active-low reset clears the storage.
module chan_pick_mux
    import cpm_pkg::*;
#(
    parameter int          N_CH      = 8,
    parameter stage_kind_e DATA_KIND = STAGE_LATCH,
    localparam int         SEL_W     = $clog2(N_CH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_CH-1:0]  data_in,
    input  logic [SEL_W-1:0] addr_in,
    input  logic             addr_hold,
    input  logic             data_ctl,
    input  logic             oe_n_a,
    input  logic             oe_n_b,
    input  logic             oe_c,
    output logic             q_true,
    output logic             q_true_oe,
    output logic             q_comp,
    output logic             q_comp_oe,
    output wire              q_true_bus,
    output wire              q_comp_bus
);

    logic [SEL_W-1:0] sel_q;
    logic [SEL_W-1:0] sel_vis;
    logic [N_CH-1:0]  dat_q;
    logic [N_CH-1:0]  dat_vis;

    // Address stage: always transparent.
    cpm_hold_stage #(.W(SEL_W)) u_addr (
        .clk  (clk),
        .rst_n(rst_n),
        .hold (addr_hold),
        .d    (addr_in),
        .held (sel_q),
        .vis  (sel_vis)
    );

    // Data stage: variant fixed at build time.
    cpm_data_stage #(.N(N_CH), .KIND(DATA_KIND)) u_data (
        .clk  (clk),
        .rst_n(rst_n),
        .ctl  (data_ctl),
        .d    (data_in),
        .held (dat_q),
        .vis  (dat_vis)
    );

    // Decode and output gating.
    cpm_out_stage #(.N(N_CH), .SW(SEL_W)) u_out (
        .data(dat_vis),
        .addr(sel_vis),
        .lo_a(oe_n_a),
        .lo_b(oe_n_b),
        .hi_c(oe_c),
        .y   (q_true),
        .w   (q_comp),
        .y_oe(q_true_oe),
        .w_oe(q_comp_oe)
    );

    // Bus pins float when their drive flag is low.
    assign q_true_bus = q_true_oe ? q_true : 1'bz;
    assign q_comp_bus = q_comp_oe ? q_comp : 1'bz;

endmodule

// File: rtl/cpm_chk.sv
`timescale 1ns/1ps
// cpm_chk: temporal checks for chan_pick_mux, attached with bind.
// Looks at the stored address and data and at the output pins.
module cpm_chk
    import cpm_pkg::*;
#(
    parameter int          N    = 8,
    parameter int          SW   = 3,
    parameter stage_kind_e KIND = STAGE_LATCH
) (
    input logic          clk,
    input logic          rst_n,
    input logic          addr_hold,
    input logic          data_ctl,
    input logic [SW-1:0] sel_q,
    input logic [N-1:0]  dat_q,
    input logic          q_true,
    input logic          q_comp,
    input logic          q_true_oe,
    input logic          q_comp_oe,
    input logic          q_true_bus,
    input logic          q_comp_bus
);

    // R3: a driven bus pin carries its data output.
    p_bus_drive_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (q_true_oe && q_comp_oe) |-> (q_true_bus == q_true && q_comp_bus == q_comp));

    // R2: driven bus pins are opposite.
    p_bus_compl_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (q_true_oe && q_comp_oe) |-> (q_true_bus != q_comp_bus));

    // R5: stored address moves only after an edge with the stage open or in reset.
    p_sel_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_q != $past(sel_q)) |-> (!$past(rst_n) || !$past(addr_hold)));

    // R9: the edge after a reset edge shows cleared storage.
    p_reset_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (sel_q == '0 && dat_q == '0));

    generate
        if (KIND == STAGE_FLOP) begin : g_edge
            // R8: data changes only after a rising strobe (or a reset).
            p_dat_capture_r8: assert property (@(posedge clk) disable iff (!rst_n)
                (dat_q != $past(dat_q)) |-> (!$past(rst_n) || ($past(data_ctl) && !$past(data_ctl, 2))));
        end else begin : g_level
            // R7: data changes only after an edge with the stage open (or a reset).
            p_dat_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
                (dat_q != $past(dat_q)) |-> (!$past(rst_n) || !$past(data_ctl)));
        end
    endgenerate

endmodule

bind chan_pick_mux cpm_chk #(.N(N_CH), .SW(SEL_W), .KIND(DATA_KIND)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .addr_hold (addr_hold),
    .data_ctl  (data_ctl),
    .sel_q     (sel_q),
    .dat_q     (dat_q),
    .q_true    (q_true),
    .q_comp    (q_comp),
    .q_true_oe (q_true_oe),
    .q_comp_oe (q_comp_oe),
    .q_true_bus(q_true_bus),
    .q_comp_bus(q_comp_bus)
);

// File: tb/sim_chan_pick_mux.sv
`timescale 1ns/1ps
// Bench for chan_pick_mux: u0 is the transparent data variant, u1 the
// edge-capture variant. They share all inputs.
module sim_chan_pick_mux;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [7:0] din;
    logic [2:0] sel;
    logic       sel_hold;
    logic       dctl;
    logic       g_a, g_b, g_c;

    logic y0, w0, yoe0, woe0;
    logic y1, w1, yoe1, woe1;
    wire  yb0, wb0, yb1, wb1;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    chan_pick_mux #(.DATA_KIND(cpm_pkg::STAGE_LATCH)) u0 (
        .clk(clk), .rst_n(rst_n), .data_in(din), .addr_in(sel),
        .addr_hold(sel_hold), .data_ctl(dctl),
        .oe_n_a(g_a), .oe_n_b(g_b), .oe_c(g_c),
        .q_true(y0), .q_true_oe(yoe0), .q_comp(w0), .q_comp_oe(woe0),
        .q_true_bus(yb0), .q_comp_bus(wb0)
    );

    chan_pick_mux #(.DATA_KIND(cpm_pkg::STAGE_FLOP)) u1 (
        .clk(clk), .rst_n(rst_n), .data_in(din), .addr_in(sel),
        .addr_hold(sel_hold), .data_ctl(dctl),
        .oe_n_a(g_a), .oe_n_b(g_b), .oe_c(g_c),
        .q_true(y1), .q_true_oe(yoe1), .q_comp(w1), .q_comp_oe(woe1),
        .q_true_bus(yb1), .q_comp_bus(wb1)
    );

    // Each entry: {data pattern, address, expected selected bit}.
    localparam logic [11:0] VEC [11] = '{
        {8'hA5, 3'd0, 1'b1}, {8'hA5, 3'd1, 1'b0}, {8'hA5, 3'd2, 1'b1},
        {8'hA5, 3'd3, 1'b0}, {8'h5A, 3'd4, 1'b1}, {8'h5A, 3'd5, 1'b0},
        {8'h5A, 3'd6, 1'b1}, {8'h5A, 3'd7, 1'b0}, {8'h80, 3'd7, 1'b1},
        {8'h01, 3'd0, 1'b1}, {8'hFE, 3'd0, 1'b0}
    };

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog (all) act=timeout exp=finished");
            summary();
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; din = 8'hFF; sel = 3'd5; sel_hold = 1'b1; dctl = 1'b1;
        g_a = 1'b0; g_b = 1'b0; g_c = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R9: storage cleared, both closed, so bit 0 of zero data.
        check("R9 u0 after reset {y,w}", {6'd0, y0, w0}, 8'b01);
        check("R9 u1 after reset {y,w}", {6'd0, y1, w1}, 8'b01);
        tick(); #1;
        check("R9 u1 no false capture at release", {7'd0, y1}, 8'd0);

        // Table walk: load, close, disturb inputs, check both variants (R1, R2, R5, R7, R8).
        for (int i = 0; i < 11; i++) begin
            din = VEC[i][11:4]; sel = VEC[i][3:1]; dctl = 1'b0; sel_hold = 1'b0;
            tick();
            dctl = 1'b1; sel_hold = 1'b1;
            tick();
            din = ~VEC[i][11:4]; sel = ~VEC[i][3:1];
            tick(); #1;
            check($sformatf("R1/R5/R7/R2 u0 entry %0d {y,w}", i), {6'd0, y0, w0}, {6'd0, VEC[i][0], ~VEC[i][0]});
            check($sformatf("R1/R5/R8/R2 u1 entry %0d {y,w}", i), {6'd0, y1, w1}, {6'd0, VEC[i][0], ~VEC[i][0]});
        end

        // R4 and R6: both stages open, outputs follow live inputs within the cycle.
        @(negedge clk);
        dctl = 1'b0; sel_hold = 1'b0; din = 8'h3C; sel = 3'd2;
        #1 check("R4/R6 u0 live bit2 of 3C", {7'd0, y0}, 8'd1);
        sel = 3'd0;
        #1 check("R4 u0 live address change", {7'd0, y0}, 8'd0);
        din = 8'hC3;
        #1 check("R6 u0 live data change", {7'd0, y0}, 8'd1);
        tick();
        // R7: close the data stage, then move data; held bit stays.
        dctl = 1'b1;
        #1 check("R7 u0 closed shows sampled data", {7'd0, y0}, 8'd1);
        din = 8'h00;
        #1 check("R7 u0 data change ignored", {7'd0, y0}, 8'd1);
        tick(); #1;
        check("R7 u0 still held after edge", {7'd0, y0}, 8'd1);

        // R8: edge-capture behaviour of u1 (address stage open, sel=3).
        din = 8'h00; sel = 3'd3; dctl = 1'b0;
        tick();
        dctl = 1'b1;
        tick(); tick();
        din = 8'hFF;
        #1 check("R8 u1 data change without strobe", {7'd0, y1}, 8'd0);
        tick(); tick(); tick(); #1;
        check("R8 u1 strobe held high no capture", {7'd0, y1}, 8'd0);
        dctl = 1'b0;
        tick(); tick(); #1;
        check("R8 u1 falling or low strobe no capture", {7'd0, y1}, 8'd0);
        dctl = 1'b1;
        #1 check("R8 u1 not updated before clock edge", {7'd0, y1}, 8'd0);
        tick(); #1;
        check("R8 u1 captured after edge", {7'd0, y1}, 8'd1);
        din = 8'h00;
        tick(); tick(); #1;
        check("R8 u1 keeps captured data", {7'd0, y1}, 8'd1);

        // R3 and R10: all enable combinations, stored state must survive.
        din = 8'h81; sel = 3'd7; dctl = 1'b0; sel_hold = 1'b0;
        tick();
        dctl = 1'b1; sel_hold = 1'b1;
        tick();
        din = 8'h00; sel = 3'd0;
        for (int g = 0; g < 8; g++) begin
            {g_a, g_b, g_c} = 3'(g);
            #1;
            check($sformatf("R3 u0 drive flags g=%0d", g), {6'd0, yoe0, woe0}, (g == 1) ? 8'b11 : 8'b00);
            check($sformatf("R3 u1 drive flags g=%0d", g), {6'd0, yoe1, woe1}, (g == 1) ? 8'b11 : 8'b00);
            if (g == 1) begin
                check("R3/R2 u0 bus pins driven", {6'd0, yb0, wb0}, 8'b10);
                check("R3/R2 u1 bus pins driven", {6'd0, yb1, wb1}, 8'b10);
            end
            tick();
        end
        {g_a, g_b, g_c} = 3'b001;
        #1;
        check("R10 u0 storage kept over enable changes", {7'd0, y0}, 8'd1);
        check("R10 u1 storage kept over enable changes", {7'd0, y1}, 8'd1);

        // R9: reset in mid-run with both stages closed.
        din = 8'hFF; sel = 3'd5;
        rst_n = 1'b0;
        tick();
        rst_n = 1'b1;
        #1;
        check("R9 u0 mid-run reset", {6'd0, y0, w0}, 8'b01);
        check("R9 u1 mid-run reset", {6'd0, y1, w1}, 8'b01);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule